// File: doc/BRIEF.md
# Dual-Channel Triangular Pulse Shaper

The block shapes two independent unsigned 16-bit sample streams, one sample per clock on each stream. Each channel produces a signed output that follows the recursion y[n] = y[n-1] + x[n] - 2*x[n-N] + x[n-2N]. This equals the sum of the newest N samples minus the sum of the N samples before them. A step on the input therefore gives a triangle whose rise and fall each last N samples. The shaped outputs feed a downstream threshold trigger. Baseline handling and host access are not part of this block.

Each channel has its own pair of cascaded delay lines of run-time length N. The second line is fed by the first. Each line is a circular buffer in memory, and one address pointer is shared by all four lines. Each line does one read and one write per clock. After reset, and whenever N changes, the block spends N clocks writing zeros into every line. Shaping then starts with an empty history, so a read never stalls. A valid strobe marks the outputs once a full 2N-sample window has entered.

Top module: `dual_tri_shaper`

## Requirements
- R1: While `rst` is high at a rising edge, both outputs go to 0 and `valid_o` goes to 0. The block then starts a priming phase.
- R2: A priming phase lasts exactly N clocks, where N is the effective length. During these clocks each delay line is loaded with zeros. The sample inputs are ignored, both outputs read 0 and `valid_o` reads 0.
- R3: From the clock after priming ends, the rising edge that takes sample x[k] sets the output to the sum of x[k-N+1..k] minus the sum of x[k-2N+1..k-N]. Samples with a negative index count as 0. This holds for every N from 1 to 1023.
- R4: The accumulator is signed and ACC_W = 16 + LEN_W + 2 bits wide. It represents the full-scale extremes +N*65535 and -N*65535 exactly, with no wrap.
- R5: The two channels share no data. Each channel's output depends only on its own input history.
- R6: `valid_o` goes high at the edge that takes the 2N-th sample after priming (sample index 2N-1). It stays high until the next priming phase and is low during priming.
- R7: When the effective length differs from the length in use at a rising edge, that edge starts a new priming phase of the new length. The old history is discarded and the accumulator is cleared.
- R8: A `len_i` value of 0 is treated as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| len_i | input | LEN_W (10) | Delay length N; 0 is treated as 1 |
| x0_i | input | 16 | Channel 0 unsigned sample |
| x1_i | input | 16 | Channel 1 unsigned sample |
| y0_o | output | ACC_W (28) | Channel 0 shaped output, two's complement |
| y1_o | output | ACC_W (28) | Channel 1 shaped output, two's complement |
| valid_o | output | 1 | Outputs cover a full 2N-sample window |

## Verification
The assertions check on every cycle:
- the shared pointer stays below the length in use;
- the length in use is never zero;
- a change of length is followed by priming;
- the strobe is low in priming and holds while the length is steady;
- the accumulator is zero after a priming clock and stays within the full-scale bound.

Only the bench's scenarios can show the arithmetic result: the exact output for each sample over many lengths, the channel separation, and the cycle on which the strobe rises. It also shows that samples driven during priming leave no trace in later outputs.

// File: rtl/tri_shaper_pkg.sv
package tri_shaper_pkg;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } shaper_state_t;

    localparam int SAMPLE_BITS = 16;

endpackage

// File: rtl/tri_shaper_dline.sv
module tri_shaper_dline #(
    parameter int W  = 16,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [W-1:0] mem_q [DEPTH];

    // Read returns the oldest entry at the pointer before it is overwritten.
    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end
endmodule

// File: rtl/tri_shaper_ctrl.sv
module tri_shaper_ctrl
    import tri_shaper_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len_i,
    output logic             prime_o,
    output logic             run_o,
    output logic [LEN_W-1:0] addr_o,
    output logic             valid_o
);
    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        shaper_state_t    st;
        logic [LEN_W-1:0] ptr;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } ctrl_t;

    ctrl_t            d, q;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] last_ptr;
    logic [CNT_W-1:0] win_last;

    always_comb begin
        len_eff  = (len_i == '0) ? LEN_W'(1) : len_i;
        last_ptr = q.len - LEN_W'(1);
        win_last = {q.len, 1'b0} - CNT_W'(1);
        d = q;
        case (q.st)
            ST_PRIME: begin
                d.valid = 1'b0;
                d.cnt   = '0;
                if (q.ptr == last_ptr) begin
                    d.st  = ST_RUN;
                    d.ptr = '0;
                end else begin
                    d.ptr = q.ptr + LEN_W'(1);
                end
            end
            default: begin
                d.ptr   = (q.ptr == last_ptr) ? '0 : q.ptr + LEN_W'(1);
                d.valid = (q.cnt >= win_last);
                if (q.cnt < win_last) d.cnt = q.cnt + CNT_W'(1);
            end
        endcase
        if (len_eff != q.len) begin
            d.st    = ST_PRIME;
            d.ptr   = '0;
            d.len   = len_eff;
            d.cnt   = '0;
            d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st    <= ST_PRIME;
            q.ptr   <= '0;
            q.len   <= len_eff;
            q.cnt   <= '0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign prime_o = (q.st == ST_PRIME);
    assign run_o   = (q.st == ST_RUN);
    assign addr_o  = q.ptr;
    assign valid_o = q.valid;

    AST_PTR_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        q.ptr < q.len); // R3
    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        q.len != '0); // R8
    AST_REPRIME_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (len_eff != q.len) |=> (prime_o && addr_o == '0)); // R7
    AST_NO_VALID_IN_PRIME: assert property (@(posedge clk) disable iff (rst)
        prime_o |-> !valid_o); // R6
    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (valid_o && run_o && len_eff == q.len) |=> valid_o); // R6
endmodule

// File: rtl/tri_shaper_chan.sv
module tri_shaper_chan #(
    parameter int SAMPLE_W = 16,
    parameter int LEN_W    = 10,
    parameter int ACC_W    = SAMPLE_W + LEN_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prime_i,
    input  logic                run_i,
    input  logic [LEN_W-1:0]    addr_i,
    input  logic [SAMPLE_W-1:0] x_i,
    output logic [ACC_W-1:0]    y_o
);
    localparam int EXT   = ACC_W - SAMPLE_W;
    localparam int BOUND = ((2 ** LEN_W) - 1) * ((2 ** SAMPLE_W) - 1);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } chan_t;

    chan_t                   d, q;
    logic                    line_we;
    logic [SAMPLE_W-1:0]     w1, w2, tap1, tap2;
    logic signed [ACC_W-1:0] xs, t1s, t2s;

    assign line_we = prime_i | run_i;
    assign w1      = prime_i ? '0 : x_i;
    assign w2      = prime_i ? '0 : tap1;

    tri_shaper_dline #(.W(SAMPLE_W), .AW(LEN_W)) u_line_a (
        .clk(clk), .we(line_we), .addr(addr_i), .wdata(w1), .rdata(tap1)
    );

    tri_shaper_dline #(.W(SAMPLE_W), .AW(LEN_W)) u_line_b (
        .clk(clk), .we(line_we), .addr(addr_i), .wdata(w2), .rdata(tap2)
    );

    always_comb begin
        xs  = signed'({{EXT{1'b0}}, x_i});
        t1s = signed'({{EXT{1'b0}}, tap1});
        t2s = signed'({{EXT{1'b0}}, tap2});
        d   = q;
        if (prime_i) begin
            d.acc = '0;
        end else if (run_i) begin
            d.acc = q.acc + xs - (t1s <<< 1) + t2s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q.acc <= '0;
        else     q     <= d;
    end

    assign y_o = q.acc;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(q.acc) <= BOUND) && (int'(q.acc) >= -BOUND)); // R4
    AST_ACC_CLEAR_IN_PRIME: assert property (@(posedge clk) disable iff (rst)
        prime_i |=> (q.acc == '0)); // R2
endmodule

// File: rtl/dual_tri_shaper.sv
module dual_tri_shaper
    import tri_shaper_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_BITS,
    parameter int LEN_W    = 10,
    parameter int ACC_W    = SAMPLE_W + LEN_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [SAMPLE_W-1:0] x0_i,
    input  logic [SAMPLE_W-1:0] x1_i,
    output logic [ACC_W-1:0]    y0_o,
    output logic [ACC_W-1:0]    y1_o,
    output logic                valid_o
);
    localparam int NCH = 2;

    logic             prime, run;
    logic [LEN_W-1:0] addr;
    logic [SAMPLE_W-1:0] x_v [NCH];
    logic [ACC_W-1:0]    y_v [NCH];

    assign x_v[0] = x0_i;
    assign x_v[1] = x1_i;
    assign y0_o   = y_v[0];
    assign y1_o   = y_v[1];

    tri_shaper_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .len_i(len_i),
        .prime_o(prime), .run_o(run), .addr_o(addr), .valid_o(valid_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tri_shaper_chan #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_chan (
            .clk(clk), .rst(rst), .prime_i(prime), .run_i(run),
            .addr_i(addr), .x_i(x_v[c]), .y_o(y_v[c])
        );
    end
endmodule

// File: tb/dual_tri_shaper_tb_top.sv
module dual_tri_shaper_tb_top;
    localparam int LEN_W = 10;
    localparam int ACC_W = 16 + LEN_W + 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LEN_W-1:0] len_i = LEN_W'(1);
    logic [15:0]      x0_i = '0, x1_i = '0;
    logic [ACC_W-1:0] y0_o, y1_o;
    logic             valid_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int h0 [4096];
    int h1 [4096];

    always #4 clk = ~clk;

    dual_tri_shaper #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .len_i(len_i), .x0_i(x0_i), .x1_i(x1_i),
        .y0_o(y0_o), .y1_o(y1_o), .valid_o(valid_o)
    );

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=190000", cyc);
            report();
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int pat(int kind, int ch, int k, int n);
        case (kind)
            0: return 32700 + ch * 60 + (k % 3);
            1: return (k < n + 3) ? 32740 + ch * 50 : 36000 + ch * 2000;
            2: return (k * 40503 + ch * 977 + n * 13 + 12345) & 65535;
            default: return (((k / n) % 2 == 0) ^ (ch == 1)) ? 65535 : 0;
        endcase
    endfunction

    function automatic longint model(int ch, int k, int n);
        longint s = 0;
        for (int j = 0; j < 2 * n; j++) begin
            if (k - j >= 0) begin
                int v = (ch == 0) ? h0[k - j] : h1[k - j];
                if (j < n) s += v;
                else       s -= v;
            end
        end
        return s;
    endfunction

    task automatic run_case(input int len, input int kind, input int nsamp, input bit do_reset);
        int    n = (len == 0) ? 1 : len;
        string rp = do_reset ? "R2" : "R7";
        string r0 = (len == 0) ? "R8" : ((kind == 3) ? "R4" : "R3");
        len_i = LEN_W'(len);
        x0_i  = 16'hBEEF;
        x1_i  = 16'h1234;
        if (do_reset) begin
            rst = 1'b1;
            step();
            step();
            chk("R1 y0 in reset", longint'($signed(y0_o)), 0);
            chk("R1 y1 in reset", longint'($signed(y1_o)), 0);
            chk("R1 valid in reset", longint'(valid_o), 0);
            rst = 1'b0;
        end else begin
            step();
        end
        // Priming: drive loud samples that must leave no trace.
        for (int p = 0; p < n; p++) begin
            x0_i = 16'hFFFF - 16'(p);
            x1_i = 16'hF00D + 16'(p);
            step();
            chk({rp, " y0 priming"}, longint'($signed(y0_o)), 0);
            chk({rp, " y1 priming"}, longint'($signed(y1_o)), 0);
            chk({rp, " valid priming"}, longint'(valid_o), 0);
        end
        for (int k = 0; k < nsamp; k++) begin
            h0[k] = pat(kind, 0, k, n);
            h1[k] = pat(kind, 1, k, n);
            x0_i = 16'(h0[k]);
            x1_i = 16'(h1[k]);
            step();
            chk(r0, longint'($signed(y0_o)), model(0, k, n));
            chk("R5", longint'($signed(y1_o)), model(1, k, n));
            chk("R6", longint'(valid_o), (k >= 2 * n - 1) ? 1 : 0);
        end
    endtask

    initial begin
        @(negedge clk);
        run_case(1,    2, 20,   1'b1);
        run_case(2,    1, 30,   1'b1);
        run_case(5,    2, 40,   1'b1);
        run_case(17,   3, 90,   1'b1);
        run_case(125,  0, 300,  1'b1);
        run_case(125,  1, 300,  1'b1);
        run_case(64,   2, 200,  1'b0);
        run_case(0,    2, 25,   1'b0);
        run_case(1023, 3, 2110, 1'b1);
        run_case(7,    3, 60,   1'b0);
        run_case(300,  2, 700,  1'b0);
        report();
    end
endmodule